// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block translates a 32-bit virtual address through a small, fully associative translation table. Each table slot covers two adjacent virtual pages, an even one and an odd one. Each half has its own physical frame number and its own attribute flags. A per-slot page mask widens the pair from two 4 KB pages up to larger power-of-two sizes.

A lookup is purely combinational. It takes the address, the current address-space identifier and the access kind. It returns a result code, the translated physical address and a writable indication. Slots are loaded one at a time through a synchronous write port that takes a slot index and every field of the slot.

All slots are compared in parallel. When several slots hit, the lowest-numbered one decides the result, which matches the outcome of a scan in index order. After reset every slot is disabled, so no address translates until software has loaded the table.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset every slot is disabled (hardware-invalidate set, both halves not valid); until the first write every lookup returns code 1 (no hit), address zero and writable low.
- R2: A slot takes part in a lookup only when its hardware-invalidate bit is clear and either its global bit is set or its stored identifier equals `curAsid`. It must also satisfy the page-number comparison of R3. If no slot qualifies, the code is 1 (no hit).
- R3: The page-number comparison ignores address bits 12..0 and ignores bit 13+k of the address and of the stored page number wherever `wrMask[k]` is 1. Masks are contiguous ones starting at bit 0, so n ones give pages of 4 KB·2^n.
- R4: The half is chosen by address bit 12+n, for a mask with n ones: 0 selects the even half, 1 selects the odd half.
- R5: If the chosen half has flag bit 0 (valid) clear, the code is 2 (invalid), whatever the access kind.
- R6: For a valid half, a fetch (`accType`=0) with flag bit 2 (no-execute) set gives code 4. A load (`accType`=1 or 3) with flag bit 3 (no-read) set gives code 5. A store (`accType`=2) never gives 4 or 5, and a fetch never gives 3 or 5.
- R7: For a valid half, a store with flag bit 1 (dirty) clear gives code 3 (modified). Every other access gives code 0 (translated), with the physical address equal to {frame, 12'b0} ORed with the address bits below bit 12+n.
- R8: `writable` is 1 only when the code is 0 and the chosen half has flag bit 1 (dirty) set.
- R9: The physical address output is zero whenever the code is not 0.
- R10: When several slots qualify, the lowest-indexed slot alone determines code, address and writable.
- R11: A write with `wrEn` high replaces slot `wrIdx` at the rising clock edge. A lookup in the same cycle still sees the previous contents, and the new contents are seen from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load one slot at the next edge |
| wrIdx | input | 4 | Slot to load |
| wrVpn | input | 19 | Virtual page-pair number (address bits 31..13) |
| wrMask | input | 19 | Page mask, bit k covers address bit 13+k |
| wrAsid | input | 8 | Address-space identifier of the slot |
| wrGlobal | input | 1 | Slot matches any identifier |
| wrHwInv | input | 1 | Hardware-invalidate: slot never matches |
| wrPfnEven | input | 20 | Frame number of the even half |
| wrPfnOdd | input | 20 | Frame number of the odd half |
| wrFlagsEven | input | 4 | Even-half flags {no-read, no-execute, dirty, valid} |
| wrFlagsOdd | input | 4 | Odd-half flags, same layout |
| vaddr | input | 32 | Virtual address to translate |
| curAsid | input | 8 | Current address-space identifier |
| accType | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| result | output | 3 | 0 translated, 1 no hit, 2 invalid, 3 modified, 4 no-execute, 5 no-read |
| paddr | output | 32 | Physical address (zero unless result is 0) |
| writable | output | 1 | Translated page may be written |

## Verification
The two functions that can fall in one cycle are a write into a slot and a lookup whose address only the new contents of that slot would translate. The bench provokes this by raising `wrEn` and presenting the matching address in the same low clock phase. It expects the old outcome (no hit) before the edge and a translation from the new frame after it. A second overlap is a multi-slot hit: a global slot duplicates the page of a lower-indexed private slot, and the bench checks that the lower slot decides whenever its identifier matches and that the global one decides otherwise.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  localparam int STROBE_SLOT_W = 8;
  localparam int FLAG_W        = 4;

  // Bit positions inside a half's flag nibble
  localparam int FLG_VALID  = 0;
  localparam int FLG_DIRTY  = 1;
  localparam int FLG_NOEXEC = 2;
  localparam int FLG_NOREAD = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } tlbp_access_e;

  typedef enum logic [2:0] {
    RES_MATCH    = 3'd0,
    RES_NOMATCH  = 3'd1,
    RES_INVALID  = 3'd2,
    RES_MODIFIED = 3'd3,
    RES_EXEC_INH = 3'd4,
    RES_READ_INH = 3'd5
  } tlbp_result_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                     wrCommit;
    logic [STROBE_SLOT_W-1:0] wrSlot;
    logic [STROBE_SLOT_W-1:0] pickSlot;
  } tlbp_strobe_t;

endpackage

// File: rtl/tlbp_datapath.sv
module tlbp_datapath
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  tlbp_strobe_t                       strobes,
  input  logic [VA_W-PAGE_SHIFT-2:0]         wrVpn,
  input  logic [VA_W-PAGE_SHIFT-2:0]         wrMask,
  input  logic [ASID_W-1:0]                  wrAsid,
  input  logic                               wrGlobal,
  input  logic                               wrHwInv,
  input  logic [PA_W-PAGE_SHIFT-1:0]         wrPfnEven,
  input  logic [PA_W-PAGE_SHIFT-1:0]         wrPfnOdd,
  input  logic [FLAG_W-1:0]                  wrFlagsEven,
  input  logic [FLAG_W-1:0]                  wrFlagsOdd,
  input  logic [VA_W-1:0]                    vaddr,
  input  logic [ASID_W-1:0]                  curAsid,
  output logic [NUM_ENTRIES-1:0]             hitVec,
  output logic [FLAG_W-1:0]                  selFlags,
  output logic [PA_W-1:0]                    paddrRaw
);

  localparam int PAIR_SHIFT = PAGE_SHIFT + 1;
  localparam int VPN_W      = VA_W - PAIR_SHIFT;
  localparam int PFN_W      = PA_W - PAGE_SHIFT;
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [VPN_W-1:0]  eVpn    [NUM_ENTRIES];
  logic [VPN_W-1:0]  eMask   [NUM_ENTRIES];
  logic [ASID_W-1:0] eAsid   [NUM_ENTRIES];
  logic              eGlobal [NUM_ENTRIES];
  logic              eHwInv  [NUM_ENTRIES];
  logic [PFN_W-1:0]  ePfnE   [NUM_ENTRIES];
  logic [PFN_W-1:0]  ePfnO   [NUM_ENTRIES];
  logic [FLAG_W-1:0] eFlagsE [NUM_ENTRIES];
  logic [FLAG_W-1:0] eFlagsO [NUM_ENTRIES];

  // Slot storage and write port
  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (!rstN) begin
        eVpn[e]    <= '0;
        eMask[e]   <= '0;
        eAsid[e]   <= '0;
        eGlobal[e] <= 1'b0;
        eHwInv[e]  <= 1'b1;
        ePfnE[e]   <= '0;
        ePfnO[e]   <= '0;
        eFlagsE[e] <= '0;
        eFlagsO[e] <= '0;
      end else if (strobes.wrCommit && strobes.wrSlot == STROBE_SLOT_W'(e)) begin
        eVpn[e]    <= wrVpn;
        eMask[e]   <= wrMask;
        eAsid[e]   <= wrAsid;
        eGlobal[e] <= wrGlobal;
        eHwInv[e]  <= wrHwInv;
        ePfnE[e]   <= wrPfnEven;
        ePfnO[e]   <= wrPfnOdd;
        eFlagsE[e] <= wrFlagsEven;
        eFlagsO[e] <= wrFlagsOdd;
      end
    end
  end

  // Parallel tag compare, one comparator per slot
  logic [VA_W-1:0] cmpMask [NUM_ENTRIES];
  logic            oddHalf [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    logic [VA_W-1:0] slotBase;
    logic            idOk;
    assign cmpMask[g] = {eMask[g], {PAIR_SHIFT{1'b1}}};
    assign slotBase   = {eVpn[g], {PAIR_SHIFT{1'b0}}};
    assign idOk       = eGlobal[g] || (eAsid[g] == curAsid);
    assign hitVec[g]  = idOk && !eHwInv[g] &&
                        ((vaddr & ~cmpMask[g]) == (slotBase & ~cmpMask[g]));
    assign oddHalf[g] = |(vaddr & cmpMask[g] & ~(cmpMask[g] >> 1));
  end

  // Read out the slot chosen by control
  logic [IDX_W-1:0] pickIdx;
  logic [PFN_W-1:0] selPfn;
  logic [VA_W-1:0]  offsetBits;

  always_comb begin
    pickIdx    = strobes.pickSlot[IDX_W-1:0];
    selFlags   = oddHalf[pickIdx] ? eFlagsO[pickIdx] : eFlagsE[pickIdx];
    selPfn     = oddHalf[pickIdx] ? ePfnO[pickIdx]   : ePfnE[pickIdx];
    offsetBits = vaddr & (cmpMask[pickIdx] >> 1);
    paddrRaw   = {selPfn, {PAGE_SHIFT{1'b0}}} | PA_W'(offsetBits);
  end

endmodule

// File: rtl/tlbp_control.sv
module tlbp_control
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                                          wrEn,
  input  logic [((NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1)-1:0] wrIdx,
  input  logic [NUM_ENTRIES-1:0]                        hitVec,
  input  logic [FLAG_W-1:0]                             selFlags,
  input  logic [1:0]                                    accType,
  output tlbp_strobe_t                                  strobes,
  output logic [2:0]                                    result,
  output logic                                          writable
);

  logic anyHit;

  // Write strobe and lowest-index pick
  always_comb begin
    strobes          = '0;
    strobes.wrCommit = wrEn;
    strobes.wrSlot   = STROBE_SLOT_W'(wrIdx);
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (hitVec[e]) strobes.pickSlot = STROBE_SLOT_W'(e);
    end
    anyHit = |hitVec;
  end

  // Result decode in fixed priority order
  always_comb begin
    if (!anyHit)
      result = RES_NOMATCH;
    else if (!selFlags[FLG_VALID])
      result = RES_INVALID;
    else if (accType == ACC_FETCH && selFlags[FLG_NOEXEC])
      result = RES_EXEC_INH;
    else if (accType != ACC_FETCH && accType != ACC_STORE && selFlags[FLG_NOREAD])
      result = RES_READ_INH;
    else if (accType == ACC_STORE && !selFlags[FLG_DIRTY])
      result = RES_MODIFIED;
    else
      result = RES_MATCH;
    writable = (result == RES_MATCH) && selFlags[FLG_DIRTY];
  end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int ASID_W      = 8,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          wrEn,
  input  logic [((NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1)-1:0] wrIdx,
  input  logic [VA_W-PAGE_SHIFT-2:0]                    wrVpn,
  input  logic [VA_W-PAGE_SHIFT-2:0]                    wrMask,
  input  logic [ASID_W-1:0]                             wrAsid,
  input  logic                                          wrGlobal,
  input  logic                                          wrHwInv,
  input  logic [PA_W-PAGE_SHIFT-1:0]                    wrPfnEven,
  input  logic [PA_W-PAGE_SHIFT-1:0]                    wrPfnOdd,
  input  logic [3:0]                                    wrFlagsEven,
  input  logic [3:0]                                    wrFlagsOdd,
  input  logic [VA_W-1:0]                               vaddr,
  input  logic [ASID_W-1:0]                             curAsid,
  input  logic [1:0]                                    accType,
  output logic [2:0]                                    result,
  output logic [PA_W-1:0]                               paddr,
  output logic                                          writable
);

  tlbp_strobe_t            strobes;
  logic [NUM_ENTRIES-1:0]  hitVec;
  logic [FLAG_W-1:0]       selFlags;
  logic [PA_W-1:0]         paddrRaw;

  tlbp_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .ASID_W(ASID_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrVpn(wrVpn), .wrMask(wrMask), .wrAsid(wrAsid),
    .wrGlobal(wrGlobal), .wrHwInv(wrHwInv),
    .wrPfnEven(wrPfnEven), .wrPfnOdd(wrPfnOdd),
    .wrFlagsEven(wrFlagsEven), .wrFlagsOdd(wrFlagsOdd),
    .vaddr(vaddr), .curAsid(curAsid),
    .hitVec(hitVec), .selFlags(selFlags), .paddrRaw(paddrRaw)
  );

  tlbp_control #(
    .NUM_ENTRIES(NUM_ENTRIES)
  ) i_control (
    .wrEn(wrEn), .wrIdx(wrIdx), .hitVec(hitVec), .selFlags(selFlags),
    .accType(accType), .strobes(strobes), .result(result),
    .writable(writable)
  );

  // Address leaves the block only on a full translation
  assign paddr = (result == RES_MATCH) ? paddrRaw : '0;

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker
  import tlbp_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [VA_W-1:0] vaddr,
  input logic [1:0]      accType,
  input logic [2:0]      result,
  input logic [PA_W-1:0] paddr,
  input logic            writable
);

  logic seenWrite;
  always_ff @(posedge clk) begin
    if (!rstN)     seenWrite <= 1'b0;
    else if (wrEn) seenWrite <= 1'b1;
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !seenWrite |-> result == RES_NOMATCH); // R1
  AST_FETCH_CODES: assert property (@(posedge clk) disable iff (!rstN)
    accType == ACC_FETCH |-> (result != RES_READ_INH && result != RES_MODIFIED)); // R6
  AST_STORE_CODES: assert property (@(posedge clk) disable iff (!rstN)
    accType == ACC_STORE |-> (result != RES_READ_INH && result != RES_EXEC_INH)); // R6
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    result == RES_MATCH |-> paddr[PAGE_SHIFT-1:0] == vaddr[PAGE_SHIFT-1:0]); // R7
  AST_WRITABLE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    writable |-> result == RES_MATCH); // R8
  AST_PADDR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    result != RES_MATCH |-> paddr == '0); // R9

endmodule

bind tlb_pair_lookup tlbp_checker #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .vaddr(vaddr), .accType(accType),
  .result(result), .paddr(paddr), .writable(writable)
);

// File: tb/test_tlb_pair_lookup.sv
module test_tlb_pair_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [18:0] wrVpn = '0, wrMask = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0, wrHwInv = 1'b0;
  logic [19:0] wrPfnEven = '0, wrPfnOdd = '0;
  logic [3:0]  wrFlagsEven = '0, wrFlagsOdd = '0;
  logic [31:0] vaddr = '0;
  logic [7:0]  curAsid = '0;
  logic [1:0]  accType = '0;
  logic [2:0]  result;
  logic [31:0] paddr;
  logic        writable;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  tlb_pair_lookup i_tlb_pair_lookup (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn),
    .wrMask(wrMask), .wrAsid(wrAsid), .wrGlobal(wrGlobal), .wrHwInv(wrHwInv),
    .wrPfnEven(wrPfnEven), .wrPfnOdd(wrPfnOdd), .wrFlagsEven(wrFlagsEven),
    .wrFlagsOdd(wrFlagsOdd), .vaddr(vaddr), .curAsid(curAsid),
    .accType(accType), .result(result), .paddr(paddr), .writable(writable)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Bench-side picture of what has been written
  bit [18:0] mVpn[NE], mMask[NE];
  bit [7:0]  mAsid[NE];
  bit        mG[NE], mHw[NE];
  bit [19:0] mPfnE[NE], mPfnO[NE];
  bit [3:0]  mFE[NE], mFO[NE];

  function automatic void predict(input bit [31:0] va, input bit [7:0] asid,
                                  input bit [1:0] acc, output bit [2:0] r,
                                  output bit [31:0] pa, output bit w);
    r = 3'd1; pa = '0; w = 1'b0;
    for (int i = 0; i < NE; i++) begin
      int hb;
      bit [31:0] low;
      bit [31:0] base;
      bit [3:0] f;
      bit [19:0] pfn;
      hb   = 12 + $countones(mMask[i]);
      low  = (32'd1 << hb) - 32'd1;
      base = {mVpn[i], 13'b0};
      if (!mHw[i] && (mG[i] || mAsid[i] == asid) && ((va >> (hb + 1)) == (base >> (hb + 1)))) begin
        f   = va[hb] ? mFO[i] : mFE[i];
        pfn = va[hb] ? mPfnO[i] : mPfnE[i];
        if (!f[0]) r = 3'd2;
        else if (acc == 2'd0 && f[2]) r = 3'd4;
        else if ((acc == 2'd1 || acc == 2'd3) && f[3]) r = 3'd5;
        else if (acc == 2'd2 && !f[1]) r = 3'd3;
        else begin
          r = 3'd0; pa = {pfn, 12'b0} | (va & low); w = f[1];
        end
        return;
      end
    end
  endfunction

  function automatic string tagFor(bit [2:0] r);
    case (r)
      3'd1:       return "R2";
      3'd2:       return "R5";
      3'd4, 3'd5: return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic compareNow(input string tag);
    bit [2:0] er; bit [31:0] ep; bit ew;
    predict(vaddr, curAsid, accType, er, ep, ew);
    if (tag == "") tag = tagFor(er);
    nChecks++;
    if (result !== er || paddr !== ep || writable !== ew) begin
      nErrors++;
      $display("FAIL %s va=%h acc=%0d asid=%0d: result %0d exp %0d, paddr %h exp %h, writable %0b exp %0b",
               tag, vaddr, accType, curAsid, result, er, paddr, ep, writable, ew);
    end
  endtask

  task automatic look(input bit [31:0] va, input bit [7:0] asid,
                      input bit [1:0] acc, input string tag);
    @(negedge clk);
    vaddr = va; curAsid = asid; accType = acc;
    #1;
    compareNow(tag);
  endtask

  task automatic setFields(input int i, input bit [18:0] vpn, input bit [18:0] msk,
                           input bit [7:0] asid, input bit g, input bit hw,
                           input bit [19:0] pe, input bit [19:0] po,
                           input bit [3:0] fe, input bit [3:0] fo);
    wrIdx = 4'(i); wrVpn = vpn; wrMask = msk; wrAsid = asid; wrGlobal = g;
    wrHwInv = hw; wrPfnEven = pe; wrPfnOdd = po; wrFlagsEven = fe; wrFlagsOdd = fo;
  endtask

  task automatic commitModel();
    mVpn[wrIdx] = wrVpn; mMask[wrIdx] = wrMask; mAsid[wrIdx] = wrAsid;
    mG[wrIdx] = wrGlobal; mHw[wrIdx] = wrHwInv; mPfnE[wrIdx] = wrPfnEven;
    mPfnO[wrIdx] = wrPfnOdd; mFE[wrIdx] = wrFlagsEven; mFO[wrIdx] = wrFlagsOdd;
  endtask

  task automatic writeSlot(input int i, input bit [18:0] vpn, input bit [18:0] msk,
                           input bit [7:0] asid, input bit g, input bit hw,
                           input bit [19:0] pe, input bit [19:0] po,
                           input bit [3:0] fe, input bit [3:0] fo);
    @(negedge clk);
    setFields(i, vpn, msk, asid, g, hw, pe, po, fe, fo);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    commitModel();
  endtask

  function automatic bit [18:0] maskOf(int i);
    return 19'((32'd1 << (i % 4)) - 32'd1);
  endfunction

  initial begin
    for (int i = 0; i < NE; i++) begin
      mVpn[i] = '0; mMask[i] = '0; mAsid[i] = '0; mG[i] = 0; mHw[i] = 1;
      mPfnE[i] = '0; mPfnO[i] = '0; mFE[i] = '0; mFO[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: empty table after reset
    for (int k = 0; k < 6; k++)
      look($urandom, 8'(k), 2'(k % 3), "R1");
    look(32'h0, 8'h0, 2'd1, "R1");

    // Populate all slots with varied sizes, identifiers and flags
    for (int i = 0; i < NE; i++) begin
      bit [18:0] m;
      m = maskOf(i);
      writeSlot(i, {15'(i * 37 + 5), 4'b0} | (m & 19'h5a5a5), m, 8'(i * 3),
                (i % 5) == 0, i == 7, 20'(i * 4099 + 17), 20'(i * 4099 + 17) ^ 20'hff00f,
                4'((i * 7 + 1) % 16), 4'((i * 11 + 3) % 16));
    end

    // Sweep: every slot, access kind, identifier, random in-pair offsets
    for (int i = 0; i < NE; i++)
      for (int acc = 0; acc < 3; acc++)
        for (int a = 0; a < 2; a++)
          for (int k = 0; k < 6; k++) begin
            bit [31:0] pm;
            pm = {maskOf(i), 13'h1fff};
            look({mVpn[i], 13'b0} ^ ($urandom & pm), mAsid[i] + 8'(a), 2'(acc), "");
          end

    // R3: bits inside a large mask do not disturb the compare
    writeSlot(3, 19'h12345, 19'h0000f, 8'd9, 0, 0, 20'h0abcd, 20'h0dcba, 4'b0011, 4'b0011);
    for (int k = 0; k < 16; k++)
      look({19'h12340 | 19'(k), 13'h0155}, 8'd9, 2'd1, "R3");
    look({19'h12355, 13'h0}, 8'd9, 2'd1, "R3");

    // R4: half chosen by bit 12+n
    for (int n = 0; n < 4; n++) begin
      writeSlot(2, 19'h2a000, maskOf(n), 8'd4, 0, 0, 20'h11111, 20'h22222, 4'b0011, 4'b0011);
      look({19'h2a000, 13'h0} | (32'd1 << (12 + n)) | 32'h7, 8'd4, 2'd2, "R4");
      look({19'h2a000, 13'h0} | 32'h9, 8'd4, 2'd0, "R4");
    end

    // R8: writable follows the dirty flag of the chosen half
    writeSlot(1, 19'h00777, 19'h0, 8'd2, 0, 0, 20'h33333, 20'h44444, 4'b0001, 4'b0011);
    for (int acc = 0; acc < 3; acc++) begin
      look({19'h00777, 13'h0040}, 8'd2, 2'(acc), "R8");
      look({19'h00777, 13'h1040}, 8'd2, 2'(acc), "R8");
    end
    look({19'h00777, 13'h1040}, 8'd2, 2'd3, "R8");

    // R9: non-translated outcomes carry a zero address
    look({19'h00777, 13'h0040}, 8'd3, 2'd1, "R9");
    look({19'h00777, 13'h0040}, 8'd2, 2'd2, "R9");

    // R10: global slot 12 duplicates private slot 4
    writeSlot(12, mVpn[4], mMask[4], 8'd200, 1, 0, 20'h55555, 20'h66666, 4'b0011, 4'b0011);
    look({mVpn[4], 13'h0100}, mAsid[4], 2'd1, "R10");
    look({mVpn[4], 13'h0100}, 8'd201, 2'd1, "R10");

    // R11: write and lookup of the same slot in one cycle
    @(negedge clk);
    setFields(15, 19'h7ff00, 19'h0, 8'd1, 1, 0, 20'h9abcd, 20'h9abce, 4'b0011, 4'b0011);
    wrEn = 1'b1;
    vaddr = {19'h7ff00, 13'h0123}; curAsid = 8'd77; accType = 2'd2;
    #1;
    compareNow("R11");
    @(negedge clk);
    wrEn = 1'b0;
    commitModel();
    #1;
    compareNow("R11");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule